// File: doc/BRIEF.md
# Ones-Complement Adder/Subtractor

This unit performs addition and subtraction on ones-complement words, 18 bits wide by default. It takes an accumulator word and an operand word together with an operation select. One clock edge later it returns the new accumulator word and a qualifying valid strobe. It also keeps an overflow flag that stays set until it is cleared.

Addition sums the two words and feeds the carry out of the top bit back into the bottom bit. It then replaces an all-ones result with all zeros, so an add never gives negative zero.

Subtraction inverts the accumulator, adds the operand with the same wrap-around carry, and inverts the sum. The negative-zero fix is not applied on this path. As a result, exactly one operand pair leaves negative zero as the result: accumulator all ones and operand all zeros.

Top module: `oc_addsub_unit`

## Requirements
- R1: Addition adds the carry out of bit W-1 back into bit 0. For example, 777776 + 777776 (octal, -1 plus -1) gives 777775 (-2), with no overflow.
- R2: An add never returns all ones. Any sum that lands on all ones, such as 000005 + 777772, is returned as 000000.
- R3: Subtraction (`in_sub` = 1) returns the bitwise inverse of (inverted accumulator + operand with wrap-around carry). The value is therefore accumulator minus operand. For example, 000007 - 000003 = 000004.
- R4: Subtracting 000000 from 777777 returns 777777. No other subtract operand pair returns all ones.
- R5: When `in_valid` is high at a rising edge, `out_valid` is high and `out_acc` holds that operation's result after that edge. When `in_valid` is low at an edge, `out_valid` is low after it.
- R6: An edge with `in_valid` low leaves `out_acc` unchanged.
- R7: An overflow event occurs on a valid operation when the two words fed to the adder have equal sign bits and the adder's sum sign bit differs from them. The two words are the accumulator (or, on subtract, its inverse) and the operand. An event sets `out_ovf` after that edge.
- R8: `out_ovf` stays set until an edge with `ovf_clr` high clears it. If a new event arrives on the same edge as `ovf_clr`, the flag is set.
- R9: While `rst_n` is low, `out_valid`, `out_acc` and `out_ovf` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation request for this edge |
| in_sub | input | 1 | 0 = add, 1 = subtract |
| in_acc | input | W | Accumulator word |
| in_opnd | input | W | Operand word |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| out_valid | output | 1 | Result of last edge's request is on out_acc |
| out_acc | output | W | New accumulator word |
| out_ovf | output | 1 | Sticky overflow flag |

## Verification
Faults in this block show up at `out_acc` on the edge right after the request. No internal state carries from one result to the next, except the held result and the flag.

A dropped wrap-around carry makes negative sums come out one too small. A misplaced negative-zero fix either leaks 777777 out of an add or hides it in the one subtract case where it must appear.

A fault in the flag logic shows up as an `out_ovf` that does not survive an idle or event-free edge. It can also show up as a flag that does not clear on the first `ovf_clr` edge.

Every operand pair of a 6-bit copy, with both operations, is compared against a modular-arithmetic model. The 18-bit copy is checked on the named corner words.

// File: rtl/oc_arith_pkg.sv
package oc_arith_pkg;

  typedef enum logic {
    OC_OP_ADD = 1'b0,
    OC_OP_SUB = 1'b1
  } oc_op_e;

endpackage

// File: rtl/oc_operand_stage.sv
module oc_operand_stage #(
  parameter int W = 18
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  input  logic         is_sub,
  output logic [W-1:0] x,
  output logic [W-1:0] y
);

  // Subtract begins by inverting the accumulator; the operand goes straight in.
  function automatic logic [W-1:0] pre_complement(logic [W-1:0] v, logic inv);
    return inv ? ~v : v;
  endfunction

  assign x = pre_complement(acc, is_sub);
  assign y = opnd;

endmodule

// File: rtl/oc_eac_adder.sv
module oc_eac_adder #(
  parameter int W = 18
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum,
  output logic         end_carry,
  output logic         wrap_carry,
  output logic         ovf_event
);

  localparam int SW = W + 1;

  function automatic logic [SW-1:0] widen_add(logic [W-1:0] p, logic [W-1:0] q);
    return {1'b0, p} + {1'b0, q};
  endfunction

  function automatic logic [SW-1:0] fold_carry(logic [SW-1:0] first);
    return {1'b0, first[W-1:0]} + {{W{1'b0}}, first[W]};
  endfunction

  logic [SW-1:0] first_pass;
  logic [SW-1:0] second_pass;

  assign first_pass  = widen_add(x, y);
  assign end_carry   = first_pass[W];
  assign second_pass = fold_carry(first_pass);
  assign sum         = second_pass[W-1:0];
  assign wrap_carry  = second_pass[W];
  assign ovf_event   = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);

endmodule

// File: rtl/oc_result_stage.sv
module oc_result_stage #(
  parameter int W = 18
) (
  input  logic [W-1:0] sum,
  input  logic         is_sub,
  output logic [W-1:0] res,
  output logic         negzero_fix
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  // Add path: all ones becomes all zeros. Subtract path: invert only.
  function automatic logic [W-1:0] finish_word(logic [W-1:0] s, logic sub);
    if (sub) begin
      return ~s;
    end
    if (s == ALL_ONES) begin
      return '0;
    end
    return s;
  endfunction

  assign negzero_fix = !is_sub && (sum == ALL_ONES);
  assign res         = finish_word(sum, is_sub);

endmodule

// File: rtl/oc_addsub_unit.sv
module oc_addsub_unit #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_sub,
  input  logic [W-1:0] in_acc,
  input  logic [W-1:0] in_opnd,
  input  logic         ovf_clr,
  output logic         out_valid,
  output logic [W-1:0] out_acc,
  output logic         out_ovf
);

  import oc_arith_pkg::*;

  oc_op_e       op_sel;
  logic [W-1:0] add_x;
  logic [W-1:0] add_y;
  logic [W-1:0] add_sum;
  logic [W-1:0] next_acc;
  logic         eac_end_carry;
  logic         eac_wrap_carry;
  logic         ovf_event;
  logic         negzero_fix;
  logic         is_sub;

  assign op_sel = oc_op_e'(in_sub);
  assign is_sub = (op_sel == OC_OP_SUB);

  oc_operand_stage #(.W(W)) u_pre (
    .acc    (in_acc),
    .opnd   (in_opnd),
    .is_sub (is_sub),
    .x      (add_x),
    .y      (add_y)
  );

  oc_eac_adder #(.W(W)) u_add (
    .x          (add_x),
    .y          (add_y),
    .sum        (add_sum),
    .end_carry  (eac_end_carry),
    .wrap_carry (eac_wrap_carry),
    .ovf_event  (ovf_event)
  );

  oc_result_stage #(.W(W)) u_post (
    .sum         (add_sum),
    .is_sub      (is_sub),
    .res         (next_acc),
    .negzero_fix (negzero_fix)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_acc   <= '0;
      out_ovf   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_acc <= next_acc;
      end
      out_ovf <= (out_ovf && !ovf_clr) || (in_valid && ovf_event);
    end
  end

endmodule

// File: rtl/oc_addsub_checker.sv
module oc_addsub_checker #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_sub,
  input logic [W-1:0] in_acc,
  input logic [W-1:0] in_opnd,
  input logic         ovf_clr,
  input logic         out_valid,
  input logic [W-1:0] out_acc,
  input logic         out_ovf,
  input logic         ovf_event,
  input logic         eac_wrap_carry,
  input logic         negzero_fix
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  AST_NO_SECOND_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    !eac_wrap_carry); // R1

  AST_ADD_NO_NEGZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_sub |=> out_acc != ALL_ONES); // R2

  AST_NEGZERO_FIX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && negzero_fix |=> out_acc == '0); // R2

  AST_SUB_NEGZERO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sub && !(in_acc == ALL_ONES && in_opnd == '0) |=> out_acc != ALL_ONES); // R4

  AST_SUB_NEGZERO_CASE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sub && in_acc == ALL_ONES && in_opnd == '0 |=> out_acc == ALL_ONES); // R4

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R5

  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R5

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_acc)); // R6

  AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ovf_event |=> out_ovf); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    out_ovf && !ovf_clr |=> out_ovf); // R8

  AST_OVF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr && !(in_valid && ovf_event) |=> !out_ovf); // R8

  AST_OVF_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ovf && !(in_valid && ovf_event) |=> !out_ovf); // R7

endmodule

bind oc_addsub_unit oc_addsub_checker #(.W(W)) u_oc_addsub_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_sub         (in_sub),
  .in_acc         (in_acc),
  .in_opnd        (in_opnd),
  .ovf_clr        (ovf_clr),
  .out_valid      (out_valid),
  .out_acc        (out_acc),
  .out_ovf        (out_ovf),
  .ovf_event      (ovf_event),
  .eac_wrap_carry (eac_wrap_carry),
  .negzero_fix    (negzero_fix)
);

// File: tb/test_oc_addsub_unit.sv
module test_oc_addsub_unit;

  localparam int WB = 18;
  localparam int WS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;

  logic          b_valid = 1'b0, b_sub = 1'b0, b_clr = 1'b0;
  logic [WB-1:0] b_acc = '0, b_opnd = '0;
  logic          b_ovalid, b_oovf;
  logic [WB-1:0] b_oacc;

  logic          s_valid = 1'b0, s_sub = 1'b0, s_clr = 1'b0;
  logic [WS-1:0] s_acc = '0, s_opnd = '0;
  logic          s_ovalid, s_oovf;
  logic [WS-1:0] s_oacc;

  int checks = 0;
  int errors = 0;

  bit            b_ovf_exp = 1'b0;
  bit            s_ovf_exp = 1'b0;
  logic [WB-1:0] b_last = '0;
  logic [WS-1:0] s_last = '0;

  always #4 clk = ~clk;

  oc_addsub_unit #(.W(WB)) i_oc_addsub_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(b_valid), .in_sub(b_sub),
    .in_acc(b_acc), .in_opnd(b_opnd), .ovf_clr(b_clr),
    .out_valid(b_ovalid), .out_acc(b_oacc), .out_ovf(b_oovf)
  );

  oc_addsub_unit #(.W(WS)) i_oc_addsub_unit_small (
    .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_sub(s_sub),
    .in_acc(s_acc), .in_opnd(s_opnd), .ovf_clr(s_clr),
    .out_valid(s_ovalid), .out_acc(s_oacc), .out_ovf(s_oovf)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0o expected %0o", req, act, exp);
    end
  endtask

  // Arithmetic reference: value modulo 2^w-1 plus a signed range test.
  task automatic model(input int w, input longint a, input longint b, input bit sub,
                       output longint res, output bit ovf);
    longint m, n, t, va, vb, tv, lim;
    m = (longint'(1) << w) - 1;
    if (!sub) begin
      res = (a + b) % m;
    end else begin
      n = (m - a) + b;
      t = (n == 0) ? 0 : ((n - 1) % m) + 1;
      res = m - t;
    end
    va  = (a >> (w - 1)) != 0 ? -(m - a) : a;
    vb  = (b >> (w - 1)) != 0 ? -(m - b) : b;
    tv  = sub ? va - vb : va + vb;
    lim = (longint'(1) << (w - 1)) - 1;
    ovf = (tv > lim) || (tv < -lim);
  endtask

  task automatic op_big(input logic [WB-1:0] a, input logic [WB-1:0] b, input bit sub,
                        input bit clr, input string req);
    longint r; bit ov;
    model(WB, longint'(a), longint'(b), sub, r, ov);
    b_valid = 1'b1; b_sub = sub; b_acc = a; b_opnd = b; b_clr = clr;
    @(negedge clk);
    b_valid = 1'b0; b_clr = 1'b0;
    b_ovf_exp = (b_ovf_exp && !clr) || ov;
    b_last = WB'(r);
    check({req, " valid R5"}, longint'(b_ovalid), 1);
    check({req, " result"}, longint'(b_oacc), r);
    check({req, " flag R7"}, longint'(b_oovf), longint'(b_ovf_exp));
  endtask

  task automatic idle_big(input bit clr, input string req);
    b_valid = 1'b0; b_clr = clr;
    b_acc = ~b_acc; b_opnd = ~b_opnd;
    @(negedge clk);
    b_clr = 1'b0;
    b_ovf_exp = b_ovf_exp && !clr;
    check({req, " idle valid R5"}, longint'(b_ovalid), 0);
    check({req, " hold R6"}, longint'(b_oacc), longint'(b_last));
    check({req, " flag R8"}, longint'(b_oovf), longint'(b_ovf_exp));
  endtask

  task automatic op_small(input logic [WS-1:0] a, input logic [WS-1:0] b, input bit sub,
                          input bit clr);
    longint r; bit ov;
    model(WS, longint'(a), longint'(b), sub, r, ov);
    s_valid = 1'b1; s_sub = sub; s_acc = a; s_opnd = b; s_clr = clr;
    @(negedge clk);
    s_valid = 1'b0; s_clr = 1'b0;
    s_ovf_exp = (s_ovf_exp && !clr) || ov;
    s_last = WS'(r);
    check(sub ? "R3 sweep sub" : "R1 sweep add", longint'(s_oacc), r);
    check("R8 sweep flag", longint'(s_oovf), longint'(s_ovf_exp));
    if (!sub) check("R2 sweep add never all ones", longint'(s_oacc == '1), 0);
    if (sub && !(a == '1 && b == '0)) check("R4 sweep sub all ones", longint'(s_oacc == '1), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset valid", longint'(b_ovalid), 0);
    check("R9 reset acc", longint'(b_oacc), 0);
    check("R9 reset flag", longint'(b_oovf), 0);
    check("R9 reset small acc", longint'(s_oacc), 0);
    rst_n = 1'b1;
    @(negedge clk);

    op_big(18'o777776, 18'o777776, 1'b0, 1'b0, "R1 -1+-1");
    check("R1 -1+-1 fixed", longint'(b_oacc), 18'o777775);
    op_big(18'o000005, 18'o777772, 1'b0, 1'b0, "R2 5+-5");
    check("R2 5+-5 fixed", longint'(b_oacc), 0);
    op_big(18'o777777, 18'o777777, 1'b0, 1'b0, "R2 -0+-0");
    check("R2 -0+-0 fixed", longint'(b_oacc), 0);
    op_big(18'o000007, 18'o000003, 1'b1, 1'b0, "R3 7-3");
    check("R3 7-3 fixed", longint'(b_oacc), 18'o000004);
    op_big(18'o777777, 18'o000000, 1'b1, 1'b0, "R4 -0 minus +0");
    check("R4 -0 minus +0 fixed", longint'(b_oacc), 18'o777777);
    op_big(18'o000000, 18'o777777, 1'b1, 1'b0, "R4 +0 minus -0");
    check("R4 +0 minus -0 fixed", longint'(b_oacc), 0);
    idle_big(1'b0, "R6");
    op_big(18'o377777, 18'o000001, 1'b0, 1'b0, "R7 positive overflow");
    check("R7 overflow fixed", longint'(b_oovf), 1);
    op_big(18'o000001, 18'o000001, 1'b0, 1'b0, "R8 sticky");
    check("R8 sticky fixed", longint'(b_oovf), 1);
    idle_big(1'b0, "R8 sticky idle");
    idle_big(1'b1, "R8 clear");
    check("R8 clear fixed", longint'(b_oovf), 0);
    op_big(18'o400000, 18'o000001, 1'b1, 1'b1, "R8 clear with event");
    check("R8 clear with event fixed", longint'(b_oovf), 1);
    idle_big(1'b1, "R8 clear again");

    for (int op = 0; op < 2; op++) begin
      for (int a = 0; a < (1 << WS); a++) begin
        for (int b = 0; b < (1 << WS); b++) begin
          op_small(WS'(a), WS'(b), bit'(op), ((a + b) % 7) == 0);
        end
      end
    end
    s_valid = 1'b0;
    @(negedge clk);
    check("R5 small valid drops", longint'(s_ovalid), 0);
    check("R6 small hold", longint'(s_oacc), longint'(s_last));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule